// File: doc/BRIEF.md
# Programmable LCD Panel Timing Generator

This block produces the raster timing for a parallel TFT panel. From one input clock it derives a pixel-clock enable and a pixel clock. It then walks a horizontal and a vertical position counter through sync, leading margin, active area and trailing margin. From those counters it produces hsync, vsync, data enable, pixel coordinates and a gated pixel data bus.

All timing comes from five 32-bit words reached over a simple write/read port: size, horizontal config, vertical config, pixel control and status. The horizontal fields are stored with offsets that the generator adds back. The status word holds two sticky flags, begin-of-frame and end-of-frame, which software polls after it sets the enable bit and clears by writing ones.

Top module: `lcd_timing_gen`

## Requirements
- R1: After synchronous reset all registers and status flags read 0. The outputs de_o, hsync_o, vsync_o, pclk_en_o, pclk_o, pix_x_o, pix_y_o and pix_data_o are 0.
- R2: Word address 0 selects size, 1 horizontal config, 2 vertical config, 3 pixel control and 4 status. A write with wr_en stores all 32 bits, except for status. A read with rd_en returns the word on rdata one clock later. Addresses 5 to 7 read as 0.
- R3: Pixel control bits 5:0 hold a divider N. pclk_en_o pulses for one clock once every N+1 clocks, and a value of 0 acts as 1.
- R4: Each line lasts the following number of pixel periods: (horizontal bits 31:26)+1 of sync, then (bits 7:0)+3 of left margin, then 16*(size bits 25:20) of active pixels, then (bits 15:8)+1 of right margin. hsync is asserted during the sync part.
- R5: Each frame lasts the following number of lines: (vertical bits 31:26) of sync, then (bits 7:0) of top margin, then (size bits 9:0) of active lines, then (bits 15:8) of bottom margin. vsync is asserted during the sync lines, and a sync width of 0 never asserts it.
- R6: de_o is high only when both counters are in their active regions. pix_x_o and pix_y_o then give the position within the active area, counted from 0, and are 0 while de_o is low.
- R7: The pixel control bits invert signals as follows: bit 22 inverts hsync_o, bit 23 inverts vsync_o, bit 21 inverts pclk_o and bit 24 inverts all of pix_data_o. pix_data_o is pix_data_i while de_o is high and 0 otherwise, before inversion. pclk_o is high, before inversion, in the first clock of each pixel period.
- R8: Pixel control bit 31 is the enable. While it is low the divider and both counters stay at their start and the outputs rest at their inactive levels. After it is set the frame starts at the first hsync/vsync pixel.
- R9: Status bit 0 is set at the end of the first pixel period of a frame. Status bit 1 is set at the end of the last pixel period of the last line. Both stay set until a status write with a 1 in that bit.
- R10: All timing outputs are registered and change one clock after the counter state they describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one clock after rd_en |
| pix_data_i | input | 18 | Pixel data for the current position |
| pix_data_o | output | 18 | Gated, polarity-adjusted pixel data |
| pclk_en_o | output | 1 | One-clock pulse per pixel period |
| pclk_o | output | 1 | Pixel clock level |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_x_o | output | 11 | Active-area column |
| pix_y_o | output | 11 | Active-area row |

## Verification
The assertions assume that N is not reduced while software expects evenly spaced pixel periods. They also assume that software programs the legal field ranges, for example a width field that gives at least 16 active pixels. The stimulus only writes configurations inside those ranges, including a divider field of 0 to exercise the clamp and a vertical sync width of 0. Polarity and enable changes are made while the generator runs, because both the checker and the reference model follow the register value cycle by cycle.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 11;
  localparam int DIV_W  = 6;

  typedef enum logic [ADDR_W-1:0] {
    RA_SIZE   = 3'd0,
    RA_HCFG   = 3'd1,
    RA_VCFG   = 3'd2,
    RA_PIXCTL = 3'd3,
    RA_STATUS = 3'd4
  } reg_addr_e;

  localparam int BIT_EN     = 31;
  localparam int BIT_PIXPOL = 24;
  localparam int BIT_VPOL   = 23;
  localparam int BIT_HPOL   = 22;
  localparam int BIT_CPOL   = 21;

  typedef struct packed {
    logic [CNT_W-1:0] sync_len;
    logic [CNT_W-1:0] lead_len;
    logic [CNT_W-1:0] act_len;
    logic [CNT_W-1:0] trail_len;
  } axis_cfg_t;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [RW-1:0] wdata,
  input  logic          set_bof,
  input  logic          set_eof,
  output logic [RW-1:0] rdata,
  output logic [RW-1:0] size_q,
  output logic [RW-1:0] hcfg_q,
  output logic [RW-1:0] vcfg_q,
  output logic [RW-1:0] pix_q,
  output logic [1:0]    stat_q
);
  logic wr_stat;
  assign wr_stat = wr_en && (addr == RA_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= '0;
      hcfg_q <= '0;
      vcfg_q <= '0;
      pix_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        RA_SIZE:   size_q <= wdata;
        RA_HCFG:   hcfg_q <= wdata;
        RA_VCFG:   vcfg_q <= wdata;
        RA_PIXCTL: pix_q  <= wdata;
        default: ;
      endcase
    end
  end

  // sticky flags: a new event in the same cycle as a clear keeps the flag set
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      if (set_bof)                 stat_q[0] <= 1'b1;
      else if (wr_stat && wdata[0]) stat_q[0] <= 1'b0;
      if (set_eof)                 stat_q[1] <= 1'b1;
      else if (wr_stat && wdata[1]) stat_q[1] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        RA_SIZE:   rdata <= size_q;
        RA_HCFG:   rdata <= hcfg_q;
        RA_VCFG:   rdata <= vcfg_q;
        RA_PIXCTL: rdata <= pix_q;
        RA_STATUS: rdata <= {{(RW-2){1'b0}}, stat_q};
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lcd_tg_clkdiv.sv
module lcd_tg_clkdiv #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] div_n,
  output logic          tick,
  output logic          phase0
);
  logic [DW-1:0] cnt;
  logic [DW-1:0] n_eff;

  // a divider of zero would exceed half the input rate; clamp it to one
  assign n_eff  = (div_n == '0) ? DW'(1) : div_n;
  assign tick   = en && (cnt >= n_eff);
  assign phase0 = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DW'(1);
  end
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
  import lcd_tg_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          step,
  input  logic [CW-1:0] sync_len,
  input  logic [CW-1:0] lead_len,
  input  logic [CW-1:0] act_len,
  input  logic [CW-1:0] trail_len,
  output logic [CW-1:0] pos,
  output logic          wrap,
  output logic          in_sync,
  output logic          in_act,
  output logic [CW-1:0] coord
);
  logic [CW:0] total;
  logic [CW:0] act_start;
  logic [CW:0] act_end;
  logic [CW:0] pos_x;

  assign pos_x     = {1'b0, pos};
  assign act_start = {1'b0, sync_len} + {1'b0, lead_len};
  assign act_end   = act_start + {1'b0, act_len};
  assign total     = act_end + {1'b0, trail_len};

  assign wrap    = (pos_x + (CW+1)'(1)) >= total;
  assign in_sync = pos_x < {1'b0, sync_len};
  assign in_act  = (pos_x >= act_start) && (pos_x < act_end);
  assign coord   = CW'(pos_x - act_start);

  always_ff @(posedge clk) begin
    if (rst || !en)  pos <= '0;
    else if (step)   pos <= wrap ? '0 : pos + CW'(1);
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int CW     = CNT_W,
  parameter int RW     = REG_W,
  parameter int AW     = ADDR_W,
  parameter int DW     = DIV_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [RW-1:0]     wdata,
  output logic [RW-1:0]     rdata,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic [DATA_W-1:0] pix_data_o,
  output logic              pclk_en_o,
  output logic              pclk_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [CW-1:0]     pix_x_o,
  output logic [CW-1:0]     pix_y_o
);
  logic [RW-1:0] size_q, hcfg_q, vcfg_q, pix_q;
  logic [1:0]    stat_bits;
  logic          cfg_en, pol_h, pol_v, pol_c, pol_d;
  logic          tick, phase0;
  logic          set_bof, set_eof;
  axis_cfg_t     hcfg, vcfg;
  logic [CW-1:0] h_pos, v_pos, h_coord, v_coord;
  logic          h_wrap, v_wrap, h_sync, v_sync, h_act, v_act;
  logic          de_n;
  logic          unused_cfg_bits;

  lcd_tg_regs #(.RW(RW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .set_bof(set_bof), .set_eof(set_eof), .rdata(rdata),
    .size_q(size_q), .hcfg_q(hcfg_q), .vcfg_q(vcfg_q), .pix_q(pix_q),
    .stat_q(stat_bits)
  );

  assign cfg_en = pix_q[BIT_EN];
  assign pol_h  = pix_q[BIT_HPOL];
  assign pol_v  = pix_q[BIT_VPOL];
  assign pol_c  = pix_q[BIT_CPOL];
  assign pol_d  = pix_q[BIT_PIXPOL];

  // horizontal fields are stored with offsets; add them back here
  assign hcfg.sync_len  = CW'(hcfg_q[31:26]) + CW'(1);
  assign hcfg.lead_len  = CW'(hcfg_q[7:0])   + CW'(3);
  assign hcfg.act_len   = CW'({size_q[25:20], 4'b0000});
  assign hcfg.trail_len = CW'(hcfg_q[15:8])  + CW'(1);

  assign vcfg.sync_len  = CW'(vcfg_q[31:26]);
  assign vcfg.lead_len  = CW'(vcfg_q[7:0]);
  assign vcfg.act_len   = CW'(size_q[9:0]);
  assign vcfg.trail_len = CW'(vcfg_q[15:8]);

  assign unused_cfg_bits = ^{hcfg_q[25:16], vcfg_q[25:16], size_q[31:26],
                             size_q[19:10], pix_q[30:25], pix_q[20:6]};

  lcd_tg_clkdiv #(.DW(DW)) u_div (
    .clk(clk), .rst(rst), .en(cfg_en), .div_n(pix_q[DW-1:0]),
    .tick(tick), .phase0(phase0)
  );

  lcd_tg_axis #(.CW(CW)) u_hax (
    .clk(clk), .rst(rst), .en(cfg_en), .step(tick),
    .sync_len(hcfg.sync_len), .lead_len(hcfg.lead_len),
    .act_len(hcfg.act_len), .trail_len(hcfg.trail_len),
    .pos(h_pos), .wrap(h_wrap), .in_sync(h_sync), .in_act(h_act),
    .coord(h_coord)
  );

  lcd_tg_axis #(.CW(CW)) u_vax (
    .clk(clk), .rst(rst), .en(cfg_en), .step(tick && h_wrap),
    .sync_len(vcfg.sync_len), .lead_len(vcfg.lead_len),
    .act_len(vcfg.act_len), .trail_len(vcfg.trail_len),
    .pos(v_pos), .wrap(v_wrap), .in_sync(v_sync), .in_act(v_act),
    .coord(v_coord)
  );

  assign set_bof = tick && (h_pos == '0) && (v_pos == '0);
  assign set_eof = tick && h_wrap && v_wrap;
  assign de_n    = cfg_en && h_act && v_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_en_o  <= 1'b0;
      pclk_o     <= 1'b0;
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      de_o       <= 1'b0;
      pix_x_o    <= '0;
      pix_y_o    <= '0;
      pix_data_o <= '0;
    end else begin
      pclk_en_o  <= tick;
      pclk_o     <= phase0 ^ pol_c;
      hsync_o    <= (cfg_en && h_sync) ^ pol_h;
      vsync_o    <= (cfg_en && v_sync) ^ pol_v;
      de_o       <= de_n;
      pix_x_o    <= de_n ? h_coord : '0;
      pix_y_o    <= de_n ? v_coord : '0;
      pix_data_o <= (de_n ? pix_data_i : '0) ^ {DATA_W{pol_d}};
    end
  end
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int CW = 11,
  parameter int AW = 3,
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          pol_h,
  input logic          pol_v,
  input logic          pclk_en_o,
  input logic          de_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic [CW-1:0] pix_x_o,
  input logic [1:0]    stat,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [RW-1:0] wdata
);
  logic clr_bof, clr_eof;
  assign clr_bof = wr_en && (addr == AW'(4)) && wdata[0];
  assign clr_eof = wr_en && (addr == AW'(4)) && wdata[1];

  assert_pce_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    pclk_en_o |=> !pclk_en_o);

  assert_hsync_idle_active_R4: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (hsync_o == $past(pol_h)));

  assert_vsync_idle_active_R5: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (vsync_o == $past(pol_v)));

  assert_row_starts_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(de_o) |-> (pix_x_o == '0));

  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!de_o && !pclk_en_o));

  assert_bof_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (stat[0] && !clr_bof) |=> stat[0]);

  assert_eof_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (stat[1] && !clr_eof) |=> stat[1]);
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.CW(CW), .AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .en(cfg_en), .pol_h(pol_h), .pol_v(pol_v),
  .pclk_en_o(pclk_en_o), .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
  .pix_x_o(pix_x_o), .stat(stat_bits), .wr_en(wr_en), .addr(addr),
  .wdata(wdata)
);

// File: tb/lcd_timing_gen_tb.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb;
  localparam int DW = 18;
  localparam int DMASK = (1 << DW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic        pce, pclk, hs, vs, de;
  logic [10:0] px, py;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lcd_timing_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pix_data_i(din), .pix_data_o(dout),
    .pclk_en_o(pce), .pclk_o(pclk), .hsync_o(hs), .vsync_o(vs), .de_o(de),
    .pix_x_o(px), .pix_y_o(py)
  );

  // ---------------- behavioural reference model ----------------
  int m_size = 0, m_hc = 0, m_vc = 0, m_pix = 0;
  int md = 0, mh = 0, mv = 0, sb = 0, se = 0;
  int e_pce = 0, e_pclk = 0, e_hs = 0, e_vs = 0, e_de = 0, e_x = 0, e_y = 0, e_dat = 0;
  int e_rd = 0;
  bit started = 0;

  always @(posedge clk) begin
    int n, en, hsw, hl, hr, w, vsw, vt, vb, ht, htot, vtot, tick, hin, vin, st;
    started = 1;
    if (rst) begin
      m_size = 0; m_hc = 0; m_vc = 0; m_pix = 0; md = 0; mh = 0; mv = 0;
      sb = 0; se = 0; e_pce = 0; e_pclk = 0; e_hs = 0; e_vs = 0; e_de = 0;
      e_x = 0; e_y = 0; e_dat = 0; e_rd = 0;
    end else begin
      n = m_pix & 63; if (n < 1) n = 1;
      en  = (m_pix >> 31) & 1;
      hsw = ((m_hc >> 26) & 63) + 1; hl = (m_hc & 255) + 3;
      hr  = ((m_hc >> 8) & 255) + 1; w = ((m_size >> 20) & 63) * 16;
      vsw = (m_vc >> 26) & 63; vt = m_vc & 255; vb = (m_vc >> 8) & 255;
      ht  = m_size & 1023;
      htot = hsw + hl + w + hr; vtot = vsw + vt + ht + vb;
      tick = (en != 0 && md >= n) ? 1 : 0;
      hin = (mh >= hsw + hl && mh < hsw + hl + w) ? 1 : 0;
      vin = (mv >= vsw + vt && mv < vsw + vt + ht) ? 1 : 0;
      e_de  = en & hin & vin;
      e_x   = e_de ? mh - hsw - hl : 0;
      e_y   = e_de ? mv - vsw - vt : 0;
      e_hs  = ((en != 0 && mh < hsw) ? 1 : 0) ^ ((m_pix >> 22) & 1);
      e_vs  = ((en != 0 && mv < vsw) ? 1 : 0) ^ ((m_pix >> 23) & 1);
      e_pce = tick;
      e_pclk = ((en != 0 && md == 0) ? 1 : 0) ^ ((m_pix >> 21) & 1);
      e_dat = ((e_de ? int'(din) : 0) ^ ((((m_pix >> 24) & 1) != 0) ? DMASK : 0)) & DMASK;
      st = (se << 1) | sb;
      if (rd_en)
        case (addr)
          3'd0: e_rd = m_size; 3'd1: e_rd = m_hc; 3'd2: e_rd = m_vc;
          3'd3: e_rd = m_pix;  3'd4: e_rd = st;   default: e_rd = 0;
        endcase
      if (wr_en && addr == 3'd4) begin
        if (wdata[0]) sb = 0;
        if (wdata[1]) se = 0;
      end
      if (tick && mh == 0 && mv == 0) sb = 1;
      if (tick && mh >= htot - 1 && mv >= vtot - 1) se = 1;
      if (en == 0) begin md = 0; mh = 0; mv = 0; end
      else if (tick) begin
        md = 0;
        if (mh >= htot - 1) begin mh = 0; mv = (mv >= vtot - 1) ? 0 : mv + 1; end
        else mh = mh + 1;
      end else md = md + 1;
      if (wr_en)
        case (addr)
          3'd0: m_size = wdata; 3'd1: m_hc = wdata; 3'd2: m_vc = wdata;
          3'd3: m_pix = wdata;  default: ;
        endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      bit ok;
      ok = 1;
      total++;
      if (int'(pce) != e_pce) begin ok = 0; $display("FAIL R3 pclk_en act=%0d exp=%0d t=%0t", pce, e_pce, $time); end
      if (int'(hs) != e_hs) begin ok = 0; $display("FAIL R4 hsync act=%0d exp=%0d t=%0t", hs, e_hs, $time); end
      if (int'(vs) != e_vs) begin ok = 0; $display("FAIL R5 vsync act=%0d exp=%0d t=%0t", vs, e_vs, $time); end
      if (int'(de) != e_de || int'(px) != e_x || int'(py) != e_y) begin
        ok = 0; $display("FAIL R6 de/x/y act=%0d/%0d/%0d exp=%0d/%0d/%0d t=%0t", de, px, py, e_de, e_x, e_y, $time);
      end
      if (int'(dout) != e_dat || int'(pclk) != e_pclk) begin
        ok = 0; $display("FAIL R7 data/pclk act=%0h/%0d exp=%0h/%0d t=%0t", dout, pclk, e_dat, e_pclk, $time);
      end
      if (int'(rdata) != e_rd) begin ok = 0; $display("FAIL R2 rdata act=%0h exp=%0h t=%0t", rdata, e_rd, $time); end
      if (!ok) bad++;
      din <= din + DW'(37);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; addr = 3'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); rd_en = 1; addr = 3'(a);
    @(negedge clk); rd_en = 0; v = int'(rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, cnt;
    idle(4);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 de", de, 0); chk("R1 hsync", hs, 0); chk("R1 vsync", vs, 0);
    chk("R1 pclk_en", pce, 0); chk("R1 data", dout, 0);
    rd(4, v); chk("R1 status", v, 0);
    rd(3, v); chk("R1 pixctl", v, 0);
    // R2 programming and readback
    wr(0, (1 << 20) | 3);
    wr(1, (1 << 26) | (1 << 8));
    wr(2, (1 << 26) | (1 << 8) | 1);
    wr(3, 1);
    rd(0, v); chk("R2 size", v, (1 << 20) | 3);
    rd(1, v); chk("R2 hcfg", v, (1 << 26) | (1 << 8));
    rd(2, v); chk("R2 vcfg", v, (1 << 26) | (1 << 8) | 1);
    rd(6, v); chk("R2 unmapped", v, 0);
    // R8 still disabled: nothing moves
    idle(10); chk("R8 disabled de", de, 0); chk("R8 disabled pce", pce, 0);
    // R4/R5/R6 run: frame = 6 lines * 23 px * 2 clocks
    wr(3, 32'h8000_0001);
    idle(600);
    rd(4, v); chk("R9 both flags set", v, 3);
    wr(4, 2); rd(4, v); chk("R9 eof cleared by write 1", v, 1);
    wr(4, 1); rd(4, v); chk("R9 bof cleared by write 1", v, 0);
    // R3 divider of 0 acts as 1
    wr(3, 32'h8000_0000);
    cnt = 0;
    repeat (100) begin @(negedge clk); if (pce) cnt++; end
    chk("R3 clamp pulses per 100", cnt, 50);
    // R7 polarities, divider 3, R5 zero vsync width
    wr(2, (1 << 8) | 1);
    wr(3, 32'h81E0_0003);
    idle(1000);
    // R8 disable with inverted syncs: rest at inactive (high) level
    wr(3, 32'h01E0_0003);
    idle(20);
    chk("R8 hsync idle level", hs, 1); chk("R8 vsync idle level", vs, 1);
    chk("R8 de low", de, 0);
    // R8 re-enable: frame restarts at sync, visible one clock later (R10)
    wr(2, (2 << 26) | (1 << 8) | 1);
    @(negedge clk); wr_en = 1; addr = 3'd3; wdata = 32'h8000_0001;
    @(negedge clk); wr_en = 0;
    chk("R10 hsync one clock after enable", hs, 1);
    chk("R8 vsync at frame start", vs, 1);
    // R4 wider line, R6 coordinates up to 63
    wr(0, (4 << 20) | 2);
    cnt = 0;
    repeat (1400) begin @(negedge clk); if (de && px == 11'd63) cnt++; end
    chk("R6 last column seen", (cnt > 0) ? 1 : 0, 1);
    idle(5);
    finish_run();
  end
endmodule